// File: doc/BRIEF.md
# Four-Phase Queue Stage Controller

This block is the control part of one stage of a self-timed queue. It talks to a producer on its left and a consumer on its right. Both channels use a return-to-zero request/acknowledge handshake in which every wire is low before and after a transfer. The stage never carries data; a separate latch can be enabled from its acknowledge wires.

Inside, the stage is split into two cooperating halves joined by a private handshake channel. The acceptor half is passive on both of its channels. It has two enumerated states. `PH_EMPTY` moves to `PH_FULL` once both the left request and the inner request are high, which raises the left acknowledge and the inner acknowledge together. `PH_FULL` returns to `PH_EMPTY` once both requests are low again. The forwarder half is built from three guarded set/reset cells: the inner request `co`, a state bit `s`, and the right request `ro`.

- `co` rises when `s` and the right acknowledge are both low, and falls when either is high.
- `s` is set by the inner acknowledge and cleared by the right acknowledge.
- `ro` rises when `s` is high and the inner acknowledge is low, and falls when `s` is low or the inner acknowledge is high.

Every cell is a register clocked by a common clock. The right-side handshake can therefore begin only after the left-side handshake has fully returned to zero.

Top module: `qs4_stage_ctrl`

## Requirements
- R1: While reset is asserted and on the first sample after release, `l_ack` and `r_req` are 0.
- R2: `l_ack` rises only on a clock edge at which `l_req` is high, and falls only on an edge at which `l_req` is low.
- R3: From reset, with the consumer idle, `l_ack` goes high no more than 3 clock cycles after `l_req` is raised.
- R4: `r_req` rises only while `l_ack` is low, and only after a left handshake that has not yet been forwarded has returned to zero. Rising edges of `r_req` never outnumber completed left handshakes.
- R5: `r_req` stays high until `r_ack` is high, and falls only on an edge at which `r_ack` is high.
- R6: After a left handshake completes, `l_ack` does not rise again until the consumer has lowered `r_ack` at the end of the matching right handshake.
- R7: `l_ack` and `r_ack` are never high together. The set and clear guards of the state bit are never enabled together.
- R8: Every left handshake is forwarded as exactly one right handshake, in order, with no deadlock, whatever the delays of producer and consumer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of all rule registers |
| rst_n | input | 1 | Active-low reset; clears every wire and the state bit |
| l_req | input | 1 | Request from the producer |
| l_ack | output | 1 | Acknowledge to the producer |
| r_req | output | 1 | Request to the consumer |
| r_ack | input | 1 | Acknowledge from the consumer |

## Verification
The assertions assume that both neighbours obey the return-to-zero protocol:
- the producer holds `l_req` high until it sees `l_ack` high, and holds it low until it sees `l_ack` low;
- the consumer raises `r_ack` only while `r_req` is high, and lowers it only after `r_req` has fallen.

The stimulus keeps within these rules by construction. A producer task and a consumer task each wait on the opposite wire before every transition. Between transitions they insert random idle gaps, with the maximum gap varied per phase, including zero gaps and a slow consumer.

// File: rtl/qs4_pkg.sv
package qs4_pkg;

    typedef enum logic {
        PH_EMPTY = 1'b0,
        PH_FULL  = 1'b1
    } acc_state_e;

endpackage

// File: rtl/qs4_gsr_cell.sv
module qs4_gsr_cell #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_g,
    input  logic clr_g,
    output logic q
);

    logic q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= INIT;
        end else if (set_g && !clr_g) begin
            q_r <= 1'b1;
        end else if (clr_g && !set_g) begin
            q_r <= 1'b0;
        end
    end

    assign q = q_r;

    // R7: a rising rule and a falling rule of one wire are never enabled together
    p_guards_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_g && clr_g));

endmodule

// File: rtl/qs4_acceptor.sv
module qs4_acceptor
    import qs4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lft_req,
    input  logic inr_req,
    output logic lft_ack,
    output logic inr_ack
);

    acc_state_e state_q;
    acc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EMPTY: if (lft_req && inr_req)   state_d = PH_FULL;
            PH_FULL:  if (!lft_req && !inr_req) state_d = PH_EMPTY;
            default:  state_d = PH_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        lft_ack = (state_q == PH_FULL);
        inr_ack = (state_q == PH_FULL);
    end

    // R2: the forked acknowledge rises only once both requests were seen high
    p_full_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lft_ack) |-> ($past(lft_req) && $past(inr_req)));

    // R2: it falls only once both requests were seen low
    p_empty_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lft_ack) |-> (!$past(lft_req) && !$past(inr_req)));

endmodule

// File: rtl/qs4_forwarder.sv
module qs4_forwarder (
    input  logic clk,
    input  logic rst_n,
    input  logic inr_ack,
    input  logic rgt_ack,
    output logic inr_req,
    output logic rgt_req
);

    logic s_bit;

    qs4_gsr_cell #(.INIT(1'b0)) u_co (
        .clk   (clk),
        .rst_n (rst_n),
        .set_g (!s_bit && !rgt_ack),
        .clr_g (s_bit || rgt_ack),
        .q     (inr_req)
    );

    qs4_gsr_cell #(.INIT(1'b0)) u_s (
        .clk   (clk),
        .rst_n (rst_n),
        .set_g (inr_ack),
        .clr_g (rgt_ack),
        .q     (s_bit)
    );

    qs4_gsr_cell #(.INIT(1'b0)) u_ro (
        .clk   (clk),
        .rst_n (rst_n),
        .set_g (s_bit && !inr_ack),
        .clr_g (!s_bit || inr_ack),
        .q     (rgt_req)
    );

    // R4: the right request rises only after the inner channel returned to zero
    p_ro_after_inner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rgt_req) |-> !$past(inr_ack));

    // R5: the right request is withdrawn only after the consumer acknowledged
    p_ro_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rgt_req) |-> $past(rgt_ack));

endmodule

// File: rtl/qs4_stage_ctrl.sv
module qs4_stage_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    output logic l_ack,
    output logic r_req,
    input  logic r_ack
);

    logic inner_req;
    logic inner_ack;

    qs4_acceptor u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .lft_req (l_req),
        .inr_req (inner_req),
        .lft_ack (l_ack),
        .inr_ack (inner_ack)
    );

    qs4_forwarder u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .inr_ack (inner_ack),
        .rgt_ack (r_ack),
        .inr_req (inner_req),
        .rgt_req (r_req)
    );

    // R6: the producer is not acknowledged while an item is still offered right
    p_lack_needs_idle_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_ack) |-> !$past(r_req));

    // R4: the right request never rises while the left acknowledge is up
    p_rreq_left_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_req) |-> !$past(l_ack));

    // R7: left acknowledge and right acknowledge never overlap
    p_acks_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_ack && r_ack));

endmodule

// File: tb/qs4_stage_ctrl_test.sv
module qs4_stage_ctrl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic li = 1'b0;
    logic ri = 1'b0;
    logic lo;
    logic ro;

    int tests = 0;
    int fails = 0;
    int sent = 0;
    int rcvd = 0;
    int exp_q[$];
    bit mon_en = 1'b0;
    bit pending = 1'b0;
    bit timed_out = 1'b0;
    logic prev_lo = 1'b0;
    logic prev_ro = 1'b0;
    logic prev_ri = 1'b0;

    always #2 clk = ~clk;

    qs4_stage_ctrl uut (
        .clk   (clk),
        .rst_n (rst_n),
        .l_req (li),
        .l_ack (lo),
        .r_req (ro),
        .r_ack (ri)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic produce(input int n, input int maxd);
        for (int i = 0; i < n; i++) begin
            int cyc;
            repeat ($urandom_range(0, maxd)) @(negedge clk);
            @(negedge clk);
            li = 1'b1;
            cyc = 0;
            while (!lo) begin
                @(negedge clk);
                cyc++;
            end
            if (sent == 0) chk(cyc <= 3, "R3 first acknowledge latency", cyc, 3);
            repeat ($urandom_range(0, maxd)) @(negedge clk);
            li = 1'b0;
            while (lo) @(negedge clk);
            exp_q.push_back(sent);
            sent++;
        end
    endtask

    task automatic consume(input int n, input int maxd);
        for (int i = 0; i < n; i++) begin
            while (!ro) @(negedge clk);
            chk(exp_q.size() > 0, "R4 right request without pending item", exp_q.size(), 1);
            if (exp_q.size() > 0) begin
                int id;
                id = exp_q.pop_front();
                chk(id == rcvd, "R8 item order", id, rcvd);
            end
            rcvd++;
            repeat ($urandom_range(0, maxd)) @(negedge clk);
            ri = 1'b1;
            while (ro) @(negedge clk);
            repeat ($urandom_range(0, maxd)) @(negedge clk);
            ri = 1'b0;
            @(negedge clk);
        end
    endtask

    // monitor: samples just after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (mon_en) begin
            if (lo && !prev_lo) begin
                chk(li, "R2 l_ack rose without l_req", li, 1);
                chk(!pending, "R6 l_ack rose before right handshake ended", pending, 0);
            end
            if (!lo && prev_lo) begin
                chk(!li, "R2 l_ack fell with l_req high", li, 0);
                pending = 1'b1;
            end
            if (ro && !prev_ro) chk(!lo, "R4 r_req rose with l_ack high", lo, 0);
            if (!ro && prev_ro) chk(ri, "R5 r_req fell without r_ack", ri, 1);
            if (!ri && prev_ri) pending = 1'b0;
            chk(!(lo && ri), "R7 l_ack and r_ack both high", {lo, ri}, 0);
        end
        prev_lo = lo;
        prev_ro = ro;
        prev_ri = ri;
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk(lo == 1'b0, "R1 l_ack in reset", lo, 0);
                chk(ro == 1'b0, "R1 r_req in reset", ro, 0);
                rst_n = 1'b1;
                @(posedge clk);
                #1;
                chk(lo == 1'b0, "R1 l_ack after release", lo, 0);
                chk(ro == 1'b0, "R1 r_req after release", ro, 0);
                mon_en = 1'b1;
                fork
                    produce(8, 0);
                    consume(8, 0);
                join
                fork
                    produce(40, 5);
                    consume(40, 5);
                join
                fork
                    produce(20, 1);
                    consume(20, 12);
                join
                fork
                    produce(20, 12);
                    consume(20, 0);
                join
                repeat (6) @(negedge clk);
                chk(rcvd == sent, "R8 delivered count", rcvd, sent);
                chk(exp_q.size() == 0, "R8 nothing left pending", exp_q.size(), 0);
                chk(ro == 1'b0 && lo == 1'b0, "R8 idle at end", {lo, ro}, 0);
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule